// File: doc/BRIEF.md
# Dual-Access Debug Control Register

This block holds a 32-bit debug control word that two masters share. Privileged software on the processor side reads and writes it through a simple strobe interface. An external debugger reaches it through a JTAG data register, which it loads with a capture step, shifts least significant bit first, and writes back with an update step. Each master may change only its own fields. Software owns the global debug enable. The debugger owns the halt/monitor selector and the seven exception trap enables. All other bits read as zero. The current word is driven out in full to the rest of the debug unit.

Two independent active-low asynchronous resets act on the register. The core reset clears only the software-owned enable. The JTAG reset clears only the debugger-owned fields and returns the JTAG data-register sequencer to its idle state. A small state machine tracks whether the shift register holds data from a capture. Its states are JT_IDLE, JT_ARMED and JT_SHIFT, and its transitions are:
- capture: any state to JT_ARMED.
- shift: JT_ARMED to JT_SHIFT.
- apply: JT_ARMED or JT_SHIFT to JT_IDLE on an update.
- trst: any state to JT_IDLE.

An update seen in JT_IDLE is dropped.

Top module: `dbg_ctl_reg`

## Requirements
- R1: Asserting `core_rst_n` low clears bit 31 (global enable) to 0 and leaves bit 30 and bits 23, 22, 20, 19, 18, 17, 16 unchanged.
- R2: Asserting `trst_n` low clears bit 30 (halt select, 1 = halt, 0 = monitor) and the trap bits 23 (FIQ), 22 (IRQ), 20 (data abort), 19 (prefetch abort), 18 (software interrupt), 17 (undefined instruction) and 16 (reset) to 0. It leaves bit 31 unchanged and returns the JTAG sequencer to JT_IDLE.
- R3: A software write with `sw_wr_en`=1 and `sw_priv`=1 loads bit 31 from `sw_wdata[31]` at the next clock edge. All other bits keep their value.
- R4: With `sw_rd_en`=1 and `sw_priv`=1, `sw_rdata` shows the full current word in the same cycle, using the bit positions of R1 and R2.
- R5: A software access without privilege leaves the word unchanged. A read of this kind returns 0. `sw_err` is high for exactly the one cycle after each such access and is low otherwise.
- R6: `jtag_capture` loads the full current word into the shift register. Each `jtag_shift` moves it one place toward bit 0, with `jtag_tdi` entering at bit 31. `jtag_tdo` always shows shift-register bit 0.
- R7: An update that follows a capture writes bits 30, 23, 22, 20, 19, 18, 17, 16 from the shift register and leaves bit 31 unchanged.
- R8: Bits 29 to 24, bit 21 and bits 15 to 0 always read 0, whatever either port writes.
- R9: A software write and a JTAG update in the same cycle both take effect, each on its own fields.
- R10: An update with no capture since the last applied update or since the JTAG reset has no effect on the word.
- R11: When several JTAG strobes are asserted together, capture wins over shift, and shift wins over update. A losing update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| core_rst_n | input | 1 | Core reset, active low, asynchronous |
| trst_n | input | 1 | JTAG reset, active low, asynchronous |
| sw_wr_en | input | 1 | Software write strobe |
| sw_rd_en | input | 1 | Software read strobe |
| sw_priv | input | 1 | Access is made in a privileged mode |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data |
| sw_err | output | 1 | One-cycle flag after an unprivileged access |
| jtag_capture | input | 1 | Load the current word into the shift register |
| jtag_shift | input | 1 | Shift one bit |
| jtag_update | input | 1 | Apply the shift register to debugger fields |
| jtag_tdi | input | 1 | Serial data in |
| jtag_tdo | output | 1 | Serial data out (shift register bit 0) |
| ctl_value | output | 32 | Current control word for the debug unit |

## Verification
The bench applies each reset while the other domain's fields are set. A design that shares one reset would lose the enable on a JTAG reset, or the traps on a core reset. It writes all ones from both ports, so a wrong write mask would show up as a stray reserved bit or as one port changing the other's field. It issues an update with no capture before it, which must be dropped, and a capture together with an update, where the capture must win. It also drives unprivileged reads and writes to confirm that the write is ignored, the read returns zero and the error pulse lasts exactly one cycle. A long random phase compares every output against a behavioural model on every clock.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    localparam int REG_W = 32;

    // Field positions decoded by the debug unit
    localparam int GE_BIT   = 31;
    localparam int HALT_BIT = 30;

    // Fields each port may write; the two masks are disjoint
    localparam logic [REG_W-1:0] SW_WMASK = 32'h8000_0000;
    localparam logic [REG_W-1:0] JT_WMASK = 32'h40DF_0000;

    typedef enum logic [1:0] {
        JT_IDLE  = 2'd0,
        JT_ARMED = 2'd1,
        JT_SHIFT = 2'd2
    } jt_state_e;

endpackage

// File: rtl/dbgreg_store.sv
module dbgreg_store
    import dbgreg_pkg::*;
#(
    parameter int             W       = REG_W,
    parameter logic [W-1:0]   SW_MASK = SW_WMASK,
    parameter logic [W-1:0]   JT_MASK = JT_WMASK
) (
    input  logic         clk,
    input  logic         core_rst_n,
    input  logic         trst_n,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    input  logic         jt_we,
    input  logic [W-1:0] jt_wdata,
    output logic [W-1:0] value
);

    logic [W-1:0] sw_q;
    logic [W-1:0] jt_q;

    // Software-owned fields live in the core reset domain
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            sw_q <= '0;
        end else if (sw_we) begin
            sw_q <= sw_wdata & SW_MASK;
        end
    end

    // Debugger-owned fields live in the JTAG reset domain
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            jt_q <= '0;
        end else if (jt_we) begin
            jt_q <= jt_wdata & JT_MASK;
        end
    end

    assign value = sw_q | jt_q;

    AST_SW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!core_rst_n || !trst_n)
        sw_we |=> ((value & SW_MASK) == ($past(sw_wdata) & SW_MASK))); // R3

    AST_SW_FIELD_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n || !trst_n)
        !sw_we |=> $stable(value & SW_MASK)); // R7

    AST_JT_FIELD_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n || !trst_n)
        !jt_we |=> $stable(value & JT_MASK)); // R3

endmodule

// File: rtl/dbgreg_sw_port.sv
module dbgreg_sw_port
    import dbgreg_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         core_rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         priv,
    input  logic [W-1:0] cur_value,
    output logic         we,
    output logic [W-1:0] rdata,
    output logic         err
);

    logic denied;

    assign denied = (wr_en || rd_en) && !priv;
    assign we     = wr_en && priv;

    always_comb begin
        rdata = '0;
        if (rd_en && priv) begin
            rdata = cur_value;
        end
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            err <= 1'b0;
        end else begin
            err <= denied;
        end
    end

    AST_ERR_ON_DENY: assert property (@(posedge clk) disable iff (!core_rst_n)
        ((wr_en || rd_en) && !priv) |=> err); // R5

    AST_ERR_ONLY_ON_DENY: assert property (@(posedge clk) disable iff (!core_rst_n)
        !((wr_en || rd_en) && !priv) |=> !err); // R5

endmodule

// File: rtl/dbgreg_jtag_dr.sv
module dbgreg_jtag_dr
    import dbgreg_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         trst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    input  logic         tdi,
    input  logic [W-1:0] cap_data,
    output logic         tdo,
    output logic         upd_we,
    output logic [W-1:0] upd_data
);

    jt_state_e    state_q;
    jt_state_e    state_d;
    logic [W-1:0] sr_q;

    // Next-state logic: capture has top priority, then shift, then update
    always_comb begin
        state_d = state_q;
        if (capture) begin
            state_d = JT_ARMED;
        end else begin
            unique case (state_q)
                JT_IDLE: begin
                    state_d = JT_IDLE;
                end
                JT_ARMED: begin
                    if (shift) begin
                        state_d = JT_SHIFT;
                    end else if (update) begin
                        state_d = JT_IDLE;
                    end
                end
                JT_SHIFT: begin
                    if (!shift && update) begin
                        state_d = JT_IDLE;
                    end
                end
                default: begin
                    state_d = JT_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            state_q <= JT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shift register
    always_ff @(posedge clk or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= '0;
        end else if (capture) begin
            sr_q <= cap_data;
        end else if (shift) begin
            sr_q <= {tdi, sr_q[W-1:1]};
        end
    end

    // Outputs
    always_comb begin
        upd_we   = 1'b0;
        upd_data = sr_q;
        tdo      = sr_q[0];
        unique case (state_q)
            JT_IDLE:  upd_we = 1'b0;
            JT_ARMED: upd_we = update && !capture && !shift;
            JT_SHIFT: upd_we = update && !capture && !shift;
            default:  upd_we = 1'b0;
        endcase
    end

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!trst_n)
        capture |=> (sr_q == $past(cap_data))); // R6

    AST_SHIFT_ENTERS_MSB: assert property (@(posedge clk) disable iff (!trst_n)
        (shift && !capture) |=> (sr_q[W-1] == $past(tdi))); // R6

    AST_UPDATE_DISARMS: assert property (@(posedge clk) disable iff (!trst_n)
        upd_we |=> (state_q == JT_IDLE)); // R10

    AST_CAPTURE_BEATS_UPDATE: assert property (@(posedge clk) disable iff (!trst_n)
        capture |-> !upd_we); // R11

endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbgreg_pkg::*;
(
    input  logic             clk,
    input  logic             core_rst_n,
    input  logic             trst_n,
    input  logic             sw_wr_en,
    input  logic             sw_rd_en,
    input  logic             sw_priv,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] sw_rdata,
    output logic             sw_err,
    input  logic             jtag_capture,
    input  logic             jtag_shift,
    input  logic             jtag_update,
    input  logic             jtag_tdi,
    output logic             jtag_tdo,
    output logic [REG_W-1:0] ctl_value
);

    logic             sw_we;
    logic             jt_we;
    logic [REG_W-1:0] jt_wdata;
    logic [REG_W-1:0] word;

    dbgreg_sw_port #(.W(REG_W)) u_sw (
        .clk        (clk),
        .core_rst_n (core_rst_n),
        .wr_en      (sw_wr_en),
        .rd_en      (sw_rd_en),
        .priv       (sw_priv),
        .cur_value  (word),
        .we         (sw_we),
        .rdata      (sw_rdata),
        .err        (sw_err)
    );

    dbgreg_jtag_dr #(.W(REG_W)) u_jtag (
        .clk      (clk),
        .trst_n   (trst_n),
        .capture  (jtag_capture),
        .shift    (jtag_shift),
        .update   (jtag_update),
        .tdi      (jtag_tdi),
        .cap_data (word),
        .tdo      (jtag_tdo),
        .upd_we   (jt_we),
        .upd_data (jt_wdata)
    );

    dbgreg_store #(
        .W       (REG_W),
        .SW_MASK (SW_WMASK),
        .JT_MASK (JT_WMASK)
    ) u_store (
        .clk        (clk),
        .core_rst_n (core_rst_n),
        .trst_n     (trst_n),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .jt_we      (jt_we),
        .jt_wdata   (jt_wdata),
        .value      (word)
    );

    assign ctl_value = word;

    AST_UNPRIV_NO_CHANGE: assert property (@(posedge clk) disable iff (!core_rst_n || !trst_n)
        (sw_wr_en && !sw_priv && !jtag_update) |=> $stable(ctl_value)); // R5

endmodule

// File: tb/sim_dbg_ctl_reg.sv
`timescale 1ns/1ps
module sim_dbg_ctl_reg;

    localparam logic [31:0] SWM  = 32'h8000_0000;
    localparam logic [31:0] JTM  = 32'h40DF_0000;
    localparam logic [31:0] ZERO_BITS = ~(SWM | JTM);

    logic        clk = 1'b0;
    logic        core_rst_n = 1'b0;
    logic        trst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic        sw_rd_en = 1'b0;
    logic        sw_priv = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        sw_err;
    logic        jtag_capture = 1'b0;
    logic        jtag_shift = 1'b0;
    logic        jtag_update = 1'b0;
    logic        jtag_tdi = 1'b0;
    logic        jtag_tdo;
    logic [31:0] ctl_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_ctl_reg u0 (
        .clk          (clk),
        .core_rst_n   (core_rst_n),
        .trst_n       (trst_n),
        .sw_wr_en     (sw_wr_en),
        .sw_rd_en     (sw_rd_en),
        .sw_priv      (sw_priv),
        .sw_wdata     (sw_wdata),
        .sw_rdata     (sw_rdata),
        .sw_err       (sw_err),
        .jtag_capture (jtag_capture),
        .jtag_shift   (jtag_shift),
        .jtag_update  (jtag_update),
        .jtag_tdi     (jtag_tdi),
        .jtag_tdo     (jtag_tdo),
        .ctl_value    (ctl_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit          m_ge = 1'b0;
    logic [31:0] m_jt = '0;
    logic [31:0] m_sr = '0;
    bit          m_armed = 1'b0;
    bit          m_err = 1'b0;

    function automatic logic [31:0] m_word();
        return ({m_ge, 31'b0} | m_jt);
    endfunction

    always @(posedge clk) begin
        logic [31:0] old_word;
        old_word = m_word();
        if (!core_rst_n) begin
            m_ge  = 1'b0;
            m_err = 1'b0;
        end else begin
            m_err = (sw_wr_en || sw_rd_en) && !sw_priv;
            if (sw_wr_en && sw_priv) m_ge = sw_wdata[31];
        end
        if (!trst_n) begin
            m_jt = '0; m_sr = '0; m_armed = 1'b0;
        end else if (jtag_capture) begin
            m_sr = old_word; m_armed = 1'b1;
        end else if (jtag_shift) begin
            m_sr = {jtag_tdi, m_sr[31:1]};
        end else if (jtag_update && m_armed) begin
            m_jt = m_sr & JTM; m_armed = 1'b0;
        end
        #2;
        if (core_rst_n && trst_n && !done) begin
            chk("R8 ctl_value", ctl_value, m_word());
            chk("R6 tdo", {31'b0, jtag_tdo}, {31'b0, m_sr[0]});
            chk("R5 sw_err", {31'b0, sw_err}, {31'b0, m_err});
            chk("R4 sw_rdata", sw_rdata, (sw_rd_en && sw_priv) ? m_word() : 32'h0);
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sw_wr_en = 0; sw_rd_en = 0; sw_priv = 0;
        jtag_capture = 0; jtag_shift = 0; jtag_update = 0; jtag_tdi = 0;
    endtask

    task automatic sw_write(input logic [31:0] d);
        sw_wr_en = 1; sw_priv = 1; sw_wdata = d;
        cyc();
        idle();
    endtask

    // Optional capture, 32 shifts (collecting tdo), optional update
    task automatic jtag_xfer(input bit cap, input logic [31:0] din, input bit upd,
                             output logic [31:0] dout);
        if (cap) begin
            jtag_capture = 1; cyc(); jtag_capture = 0;
        end
        for (int i = 0; i < 32; i++) begin
            dout[i] = jtag_tdo;
            jtag_shift = 1; jtag_tdi = din[i];
            cyc();
        end
        jtag_shift = 0; jtag_tdi = 0;
        if (upd) begin
            jtag_update = 1; cyc(); jtag_update = 0;
        end
    endtask

    initial begin
        logic [31:0] got;
        idle();
        repeat (2) @(negedge clk);
        core_rst_n = 1; trst_n = 1;
        cyc();
        chk("R1 reset word", ctl_value, 32'h0);
        chk("R2 reset word", ctl_value, 32'h0);

        sw_write(32'hFFFF_FFFF);
        chk("R3 sw sets enable only", ctl_value, 32'h8000_0000);
        chk("R8 reserved after sw write", ctl_value & ZERO_BITS, 32'h0);

        jtag_xfer(1, 32'hFFFF_FFFF, 1, got);
        chk("R6 captured word", got, 32'h8000_0000);
        chk("R7 jtag fields written", ctl_value, 32'hC0DF_0000);
        chk("R8 reserved after jtag write", ctl_value & ZERO_BITS, 32'h0);

        sw_wr_en = 1; sw_rd_en = 1; sw_priv = 0; sw_wdata = 32'h0;
        #1 chk("R5 unpriv read zero", sw_rdata, 32'h0);
        cyc(); idle();
        chk("R5 err pulse", {31'b0, sw_err}, 32'h1);
        chk("R5 unpriv write ignored", ctl_value, 32'hC0DF_0000);
        cyc();
        chk("R5 err one cycle", {31'b0, sw_err}, 32'h0);

        sw_rd_en = 1; sw_priv = 1;
        #1 chk("R4 priv read", sw_rdata, 32'hC0DF_0000);
        cyc(); idle();

        core_rst_n = 0; cyc(); core_rst_n = 1; cyc();
        chk("R1 core reset keeps jtag fields", ctl_value, 32'h40DF_0000);

        sw_write(32'h8000_0000);
        trst_n = 0; cyc(); trst_n = 1; cyc();
        chk("R2 trst keeps enable", ctl_value, 32'h8000_0000);

        jtag_xfer(1, 32'h4000_0000, 1, got);
        chk("R7 halt bit set", ctl_value, 32'hC000_0000);
        jtag_xfer(0, 32'h00DF_0000, 1, got);
        chk("R10 update without capture ignored", ctl_value, 32'hC000_0000);

        jtag_xfer(1, 32'h0084_0000, 0, got);
        jtag_update = 1; sw_wr_en = 1; sw_priv = 1; sw_wdata = 32'h0;
        cyc(); idle();
        chk("R9 both ports in one cycle", ctl_value, 32'h0084_0000);

        jtag_xfer(1, 32'h4000_0000, 0, got);
        jtag_capture = 1; jtag_update = 1;
        cyc(); idle();
        chk("R11 update loses to capture", ctl_value, 32'h0084_0000);
        jtag_xfer(0, 32'h0, 0, got);
        chk("R11 capture took effect", got, 32'h0084_0000);

        for (int n = 0; n < 3000; n++) begin
            sw_wr_en     = ($urandom_range(3) == 0);
            sw_rd_en     = $urandom_range(1);
            sw_priv      = $urandom_range(1);
            sw_wdata     = $urandom;
            jtag_capture = ($urandom_range(15) == 0);
            jtag_shift   = $urandom_range(1);
            jtag_update  = ($urandom_range(7) == 0);
            jtag_tdi     = $urandom_range(1);
            core_rst_n   = ($urandom_range(199) != 0);
            trst_n       = ($urandom_range(199) != 0);
            cyc();
        end
        core_rst_n = 1; trst_n = 1; idle();
        cyc(); cyc();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule